// File: doc/BRIEF.md
# TLB lookup and fault unit

This block translates a 32-bit virtual address through a small set-associative TLB with 8 KiB pages. It also classifies every access. Software loads entries through a write port. Each entry is a pair of 32-bit words: a tag word that holds the virtual page and an owner process ID, and a data word that holds the physical frame and the permission flags. A lookup picks one set from the low bits of the virtual page and compares all ways of that set at once. The matching entry is then checked against the global enables in the protection-configuration word, the requester's process ID and the access direction.

The result comes back one clock after the request. It carries a physical address and, on a fault, a 4-bit fault vector. A fault also rewrites the fault-cause register. A miss or an invalid entry also rewrites the refill-selection register, which points refill software at the slot to fill. A combinational readback port returns the virtual address of the entry that the selection register addresses. When the MMU-enable input is low the block passes addresses through untranslated.

Control is a two-state machine. ST_IDLE means no result is presented. ST_RESP means a result is presented for one cycle. A sampled request moves either state to ST_RESP. A cycle with no request moves either state to ST_IDLE.

Top module: `tlbf_unit`

## Requirements
- R1: The set index is vaddr[16:13]. A way hits when its tag word bits 31..13 equal vaddr[31:13]. A hit with no fault gives rsp_paddr = {data[31:13], vaddr[12:0]}, rsp_fault = 0 and rsp_vec = 0. Data-word bits 2 and 0 and configuration bits 18 and 17 have no effect.
- R2: When several ways of a set match, the lowest-numbered way is used.
- R3: A request sampled at a rising edge sets rsp_valid high after that edge, with its result. rsp_valid is low after any edge where no request was sampled.
- R4: If configuration bit 16 is set and data-word bit 3 (valid) is clear, the result is vector 0x9. This check takes precedence over R5 and R6.
- R5: Otherwise, the result is vector 0xA when all three hold: data-word bit 4 (global) is clear, tag-word bits 7..0 are not 0xFF, and those bits differ from req_pid. This check takes precedence over R6.
- R6: Otherwise, the result is vector 0xB for a write when configuration bit 19 is set and data-word bit 1 (writable) is clear.
- R7: When no way matches, the result is vector 0x8.
- R8: Any fault gives rsp_fault = 1 and rsp_paddr = 0. It also loads fault_cause with {vaddr[31:13], 3'b000, code, req_pid}, where code is 2'b10 for a write and 2'b01 for a read. Results without a fault leave fault_cause unchanged.
- R9: Vectors 0x8 and 0x9 load refill_sel with the set index in bits 3..0 and 0 in the way field, bits 5..4. Every other result leaves refill_sel unchanged.
- R10: rb_vaddr is, combinationally, tag-word bits 31..13 of the entry at set refill_sel[3..0] and way refill_sel[5..4], followed by 13 zero bits.
- R11: While mmu_en is low, a request gives rsp_paddr = vaddr and rsp_fault = 0, and leaves fault_cause and refill_sel unchanged.
- R12: Reset clears every entry, fault_cause, refill_sel and rsp_valid. A cleared entry reads as an invalid page 0 owned by process 0.
- R13: A TLB write is seen by lookups sampled at later edges. A lookup sampled at the same edge as the write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mmu_en | input | 1 | Translation enable; low means pass-through |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_pid | input | 8 | Current process ID |
| prot_cfg | input | 32 | Protection configuration (bit 19 write check, bit 16 valid check) |
| tlb_wr_en | input | 1 | Entry write strobe |
| tlb_wr_set | input | 4 | Set to write |
| tlb_wr_way | input | 2 | Way to write |
| tlb_wr_hi | input | 32 | Tag word to store |
| tlb_wr_lo | input | 32 | Data word to store |
| rsp_valid | output | 1 | Result presented this cycle |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_fault | output | 1 | Result is a fault |
| rsp_vec | output | 4 | Fault vector (0 when there is no fault) |
| fault_cause | output | 32 | Cause register |
| refill_sel | output | 6 | Refill selection register |
| rb_vaddr | output | 32 | Virtual address of the selected entry |

## Verification
The hardest cases to reach are the ones where two checks could fire at once. An invalid entry with a foreign PID must give 0x9. A non-global, non-writable entry written by a foreign process must give 0xA. Several ways with the same tag must pick the lowest way. Reaching these needs deliberately inconsistent entries, and the bench loads them through the write port before a vector table walks lookups over them. The bench also proves that a write becomes visible one cycle late by issuing a lookup in the same cycle as the write, then repeating it.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;

    typedef enum logic [3:0] {
        VEC_NONE    = 4'h0,
        VEC_MISS    = 4'h8,
        VEC_INVALID = 4'h9,
        VEC_PID     = 4'hA,
        VEC_WPROT   = 4'hB
    } tlbf_vec_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } tlbf_state_e;

    localparam logic [1:0] CAUSE_READ  = 2'b01;
    localparam logic [1:0] CAUSE_WRITE = 2'b10;

    // Bit positions decoded from the configuration word and the data word
    localparam int CFG_WEN_BIT = 19;
    localparam int CFG_VEN_BIT = 16;
    localparam int LO_G_BIT    = 4;
    localparam int LO_V_BIT    = 3;
    localparam int LO_W_BIT    = 1;

endpackage

// File: rtl/tlbf_store.sv
module tlbf_store #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SET_W-1:0]           wr_set,
    input  logic [WAY_W-1:0]           wr_way,
    input  logic [31:0]                wr_hi,
    input  logic [31:0]                wr_lo,
    input  logic [SET_W-1:0]           rd_set,
    output logic [NUM_WAYS-1:0][31:0]  rd_hi,
    output logic [NUM_WAYS-1:0][31:0]  rd_lo,
    input  logic [SET_W-1:0]           rb_set,
    input  logic [WAY_W-1:0]           rb_way,
    output logic [31:0]                rb_hi
);

    logic [NUM_SETS-1:0][NUM_WAYS-1:0][31:0] hi_q;
    logic [NUM_SETS-1:0][NUM_WAYS-1:0][31:0] lo_q;

    // R12: all entries clear on reset; R13: writes land at the edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (wr_en) begin
            hi_q[wr_set][wr_way] <= wr_hi;
            lo_q[wr_set][wr_way] <= wr_lo;
        end
    end

    assign rd_hi = hi_q[rd_set];
    assign rd_lo = lo_q[rd_set];
    assign rb_hi = hi_q[rb_set][rb_way];

endmodule

// File: rtl/tlbf_check.sv
module tlbf_check
    import tlbf_pkg::*;
#(
    parameter int NUM_WAYS  = 4,
    parameter int PAGE_BITS = 13,
    parameter int PID_W     = 8,
    localparam int VPN_W = 32 - PAGE_BITS
) (
    input  logic [31:0]               vaddr,
    input  logic                      is_write,
    input  logic [PID_W-1:0]          cur_pid,
    input  logic [31:0]               cfg,
    input  logic [NUM_WAYS-1:0][31:0] way_hi,
    input  logic [NUM_WAYS-1:0][31:0] way_lo,
    output tlbf_vec_e                 vec,
    output logic [VPN_W-1:0]          pfn
);

    logic [NUM_WAYS-1:0] tag_eq;
    logic [NUM_WAYS-1:0] first_hit;
    logic [31:0]         hit_hi;
    logic [31:0]         hit_lo;
    logic [PID_W-1:0]    e_pid;
    logic                e_g, e_v, e_w;

    // R1 tag compare per way; R2 lowest matching way wins
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        assign tag_eq[w] = (way_hi[w][31:PAGE_BITS] == vaddr[31:PAGE_BITS]);
        if (w == 0) begin : g_first
            assign first_hit[w] = tag_eq[w];
        end else begin : g_rest
            assign first_hit[w] = tag_eq[w] & ~(|tag_eq[w-1:0]);
        end
    end

    always_comb begin
        hit_hi = '0;
        hit_lo = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (first_hit[w]) begin
                hit_hi = hit_hi | way_hi[w];
                hit_lo = hit_lo | way_lo[w];
            end
        end
    end

    assign e_pid = hit_hi[PID_W-1:0];
    assign e_g   = hit_lo[LO_G_BIT];
    assign e_v   = hit_lo[LO_V_BIT];
    assign e_w   = hit_lo[LO_W_BIT];
    assign pfn   = hit_lo[31:PAGE_BITS];

    // R4..R7 fixed check priority
    always_comb begin
        if (first_hit == '0) begin
            vec = VEC_MISS;
        end else if (cfg[CFG_VEN_BIT] && !e_v) begin
            vec = VEC_INVALID;
        end else if (!e_g && (e_pid != '1) && (e_pid != cur_pid)) begin
            vec = VEC_PID;
        end else if (is_write && cfg[CFG_WEN_BIT] && !e_w) begin
            vec = VEC_WPROT;
        end else begin
            vec = VEC_NONE;
        end
    end

    logic unused_fields;
    assign unused_fields = ^{cfg[31:CFG_WEN_BIT+1], cfg[CFG_WEN_BIT-1:CFG_VEN_BIT+1],
                             cfg[CFG_VEN_BIT-1:0], vaddr[PAGE_BITS-1:0],
                             hit_hi[PAGE_BITS-1:PID_W], hit_lo[PAGE_BITS-1:LO_G_BIT+1],
                             hit_lo[LO_V_BIT-1:LO_W_BIT+1], hit_lo[LO_W_BIT-1:0]};

endmodule

// File: rtl/tlbf_unit.sv
module tlbf_unit
    import tlbf_pkg::*;
#(
    parameter int NUM_SETS  = 16,
    parameter int NUM_WAYS  = 4,
    parameter int PAGE_BITS = 13,
    parameter int PID_W     = 8,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS),
    localparam int SEL_W = SET_W + WAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mmu_en,
    input  logic              req_valid,
    input  logic [31:0]       req_vaddr,
    input  logic              req_write,
    input  logic [PID_W-1:0]  req_pid,
    input  logic [31:0]       prot_cfg,
    input  logic              tlb_wr_en,
    input  logic [SET_W-1:0]  tlb_wr_set,
    input  logic [WAY_W-1:0]  tlb_wr_way,
    input  logic [31:0]       tlb_wr_hi,
    input  logic [31:0]       tlb_wr_lo,
    output logic              rsp_valid,
    output logic [31:0]       rsp_paddr,
    output logic              rsp_fault,
    output logic [3:0]        rsp_vec,
    output logic [31:0]       fault_cause,
    output logic [SEL_W-1:0]  refill_sel,
    output logic [31:0]       rb_vaddr
);

    localparam int VPN_W = 32 - PAGE_BITS;
    localparam int PAD_W = PAGE_BITS - 2 - PID_W;

    tlbf_state_e                 state_q, state_d;
    logic [SET_W-1:0]            req_set;
    logic [NUM_WAYS-1:0][31:0]   set_hi, set_lo;
    logic [31:0]                 rb_hi;
    tlbf_vec_e                   chk_vec;
    logic [VPN_W-1:0]            chk_pfn;

    assign req_set = req_vaddr[PAGE_BITS+SET_W-1:PAGE_BITS];

    tlbf_store #(
        .NUM_SETS (NUM_SETS),
        .NUM_WAYS (NUM_WAYS)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tlb_wr_en),
        .wr_set (tlb_wr_set),
        .wr_way (tlb_wr_way),
        .wr_hi  (tlb_wr_hi),
        .wr_lo  (tlb_wr_lo),
        .rd_set (req_set),
        .rd_hi  (set_hi),
        .rd_lo  (set_lo),
        .rb_set (refill_sel[SET_W-1:0]),
        .rb_way (refill_sel[SEL_W-1:SET_W]),
        .rb_hi  (rb_hi)
    );

    tlbf_check #(
        .NUM_WAYS  (NUM_WAYS),
        .PAGE_BITS (PAGE_BITS),
        .PID_W     (PID_W)
    ) u_check (
        .vaddr    (req_vaddr),
        .is_write (req_write),
        .cur_pid  (req_pid),
        .cfg      (prot_cfg),
        .way_hi   (set_hi),
        .way_lo   (set_lo),
        .vec      (chk_vec),
        .pfn      (chk_pfn)
    );

    // State transitions (R3)
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign rsp_valid = (state_q == ST_RESP);

    // Result, cause and selection registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_paddr   <= '0;
            rsp_fault   <= 1'b0;
            rsp_vec     <= VEC_NONE;
            fault_cause <= '0;
            refill_sel  <= '0;
        end else if (req_valid) begin
            if (!mmu_en) begin
                rsp_paddr <= req_vaddr;
                rsp_fault <= 1'b0;
                rsp_vec   <= VEC_NONE;
            end else if (chk_vec == VEC_NONE) begin
                rsp_paddr <= {chk_pfn, req_vaddr[PAGE_BITS-1:0]};
                rsp_fault <= 1'b0;
                rsp_vec   <= VEC_NONE;
            end else begin
                rsp_paddr   <= '0;
                rsp_fault   <= 1'b1;
                rsp_vec     <= chk_vec;
                fault_cause <= {req_vaddr[31:PAGE_BITS], {PAD_W{1'b0}},
                                (req_write ? CAUSE_WRITE : CAUSE_READ), req_pid};
                if (chk_vec == VEC_MISS || chk_vec == VEC_INVALID) begin
                    refill_sel <= {{WAY_W{1'b0}}, req_set};
                end
            end
        end
    end

    assign rb_vaddr = {rb_hi[31:PAGE_BITS], {PAGE_BITS{1'b0}}};

    logic unused_rb;
    assign unused_rb = ^rb_hi[PAGE_BITS-1:0];

    // Assertions
    a_r3_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r3_no_resp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r11_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mmu_en) |=> (rsp_paddr == $past(req_vaddr)) && !rsp_fault);

    a_r8_fault_flag_matches_vec: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_vec != VEC_NONE)));

    a_r8_cause_held_on_success: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> $stable(fault_cause));

    a_r9_sel_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_vec == VEC_MISS) |->
        (refill_sel == {{WAY_W{1'b0}}, $past(req_vaddr[PAGE_BITS+SET_W-1:PAGE_BITS])}));

    a_r6_wprot_only_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_vec == VEC_WPROT) |-> ($past(req_write) && $past(prot_cfg[CFG_WEN_BIT])));

endmodule

// File: tb/tlbf_unit_bench.sv
module tlbf_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mmu_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [7:0]  req_pid = '0;
    logic [31:0] prot_cfg = '0;
    logic        tlb_wr_en = 1'b0;
    logic [3:0]  tlb_wr_set = '0;
    logic [1:0]  tlb_wr_way = '0;
    logic [31:0] tlb_wr_hi = '0;
    logic [31:0] tlb_wr_lo = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic [3:0]  rsp_vec;
    logic [31:0] fault_cause;
    logic [5:0]  refill_sel;
    logic [31:0] rb_vaddr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tlbf_unit u_tlbf_unit (
        .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en), .req_valid(req_valid),
        .req_vaddr(req_vaddr), .req_write(req_write), .req_pid(req_pid),
        .prot_cfg(prot_cfg), .tlb_wr_en(tlb_wr_en), .tlb_wr_set(tlb_wr_set),
        .tlb_wr_way(tlb_wr_way), .tlb_wr_hi(tlb_wr_hi), .tlb_wr_lo(tlb_wr_lo),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .rsp_vec(rsp_vec), .fault_cause(fault_cause), .refill_sel(refill_sel),
        .rb_vaddr(rb_vaddr)
    );

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic [7:0]  pid;
        logic        ven;
        logic        wen;
        logic        en;
        logic [3:0]  vec;
        logic [31:0] pa;
        logic [31:0] rb;
        logic [3:0]  rq;
    } row_t;

    localparam int NROW = 20;
    localparam row_t ROWS [NROW] = '{
        '{32'h0000_2ABC, 1'b0, 8'h05, 1'b1, 1'b1, 1'b1, 4'h0, 32'h2468_AABC, 32'h0, 4'd1},      // R1 hit
        '{32'h0000_2010, 1'b1, 8'h05, 1'b1, 1'b1, 1'b1, 4'h0, 32'h2468_A010, 32'h0, 4'd1},      // R1 write to writable
        '{32'h0000_2010, 1'b0, 8'h06, 1'b1, 1'b1, 1'b1, 4'hA, 32'h0, 32'h0, 4'd5},             // R5 foreign pid
        '{32'h0002_4004, 1'b0, 8'h07, 1'b1, 1'b1, 1'b1, 4'h0, 32'h1579_A004, 32'h0, 4'd5},      // R5 global entry
        '{32'h0002_4004, 1'b1, 8'h07, 1'b1, 1'b1, 1'b1, 4'hB, 32'h0, 32'h0, 4'd6},             // R6 write protect
        '{32'h0002_4004, 1'b1, 8'h07, 1'b1, 1'b0, 1'b1, 4'h0, 32'h1579_A004, 32'h0, 4'd6},      // R6 check off
        '{32'h0000_6008, 1'b0, 8'h05, 1'b1, 1'b1, 1'b1, 4'h9, 32'h0, 32'h0002_6000, 4'd4},      // R4 invalid
        '{32'h0000_6008, 1'b0, 8'h05, 1'b0, 1'b1, 1'b1, 4'h0, 32'h0066_6008, 32'h0002_6000, 4'd4}, // R4 check off
        '{32'hFFFE_8FFF, 1'b0, 8'h42, 1'b1, 1'b1, 1'b1, 4'h0, 32'h0008_8FFF, 32'h0002_6000, 4'd5}, // R5 pid 0xFF
        '{32'h0000_6000, 1'b0, 8'h06, 1'b1, 1'b1, 1'b1, 4'h9, 32'h0, 32'h0002_6000, 4'd4},      // R4 before R5
        '{32'h0001_0000, 1'b1, 8'h21, 1'b1, 1'b1, 1'b1, 4'hA, 32'h0, 32'h0002_6000, 4'd5},      // R5 before R6
        '{32'h0001_0000, 1'b1, 8'h20, 1'b1, 1'b1, 1'b1, 4'hB, 32'h0, 32'h0002_6000, 4'd6},      // R6
        '{32'h0000_A123, 1'b0, 8'h03, 1'b1, 1'b1, 1'b1, 4'h8, 32'h0, 32'h0, 4'd7},             // R7 miss set 5
        '{32'h0000_0040, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 4'h0, 32'h0000_0040, 32'h0, 4'd12},     // R12 cleared entry
        '{32'h0000_0040, 1'b0, 8'h01, 1'b0, 1'b1, 1'b1, 4'hA, 32'h0, 32'h0, 4'd12},            // R12 cleared, pid 0
        '{32'h0000_0040, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 4'h9, 32'h0, 32'h0, 4'd12},            // R12 cleared, invalid
        '{32'h0002_2000, 1'b1, 8'h09, 1'b1, 1'b1, 1'b1, 4'h8, 32'h0, 32'h0000_2000, 4'd10},     // R10 readback set 1
        '{32'h0000_C00C, 1'b0, 8'h05, 1'b1, 1'b1, 1'b1, 4'h0, 32'h0022_200C, 32'h0000_2000, 4'd2}, // R2 lowest way
        '{32'h1234_5678, 1'b1, 8'h05, 1'b1, 1'b1, 1'b0, 4'h0, 32'h1234_5678, 32'h0000_2000, 4'd11}, // R11 bypass
        '{32'h0000_A000, 1'b0, 8'h05, 1'b1, 1'b1, 1'b0, 4'h0, 32'h0000_A000, 32'h0000_2000, 4'd11}  // R11 bypass of miss
    };

    function automatic logic [31:0] mk_hi(input logic [18:0] vpn, input logic [7:0] pid);
        return {vpn, 5'b0, pid};
    endfunction

    // kernel (bit 2) and execute (bit 0) set everywhere: R1 says they are ignored
    function automatic logic [31:0] mk_lo(input logic [18:0] pfn, input logic g, input logic v, input logic w);
        return {pfn, 8'h00, g, v, 1'b1, w, 1'b1};
    endfunction

    function automatic logic [31:0] mk_cfg(input logic wen, input logic ven);
        return {12'h000, wen, 2'b11, ven, 16'hFFFF};
    endfunction

    function automatic logic [31:0] mk_cause(input logic [31:0] va, input logic wr, input logic [7:0] pid);
        return {va[31:13], 3'b000, (wr ? 2'b10 : 2'b01), pid};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [3:0] s, input logic [1:0] w, input logic [31:0] hi, input logic [31:0] lo);
        @(negedge clk);
        tlb_wr_en = 1'b1; tlb_wr_set = s; tlb_wr_way = w; tlb_wr_hi = hi; tlb_wr_lo = lo;
        @(negedge clk);
        tlb_wr_en = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R3: watchdog expired, actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] cause_m;
        logic [5:0]  sel_m;
        cause_m = '0;
        sel_m = '0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 rsp_valid", {31'b0, rsp_valid}, 32'h0);
        chk("R12 cause", fault_cause, 32'h0);
        chk("R12 sel", {26'b0, refill_sel}, 32'h0);
        rst_n = 1'b1;
        mmu_en = 1'b1;
        @(negedge clk);
        chk("R12 rb_vaddr", rb_vaddr, 32'h0);

        load(4'd1, 2'd0, mk_hi(19'h00001, 8'h05), mk_lo(19'h12345, 1'b0, 1'b1, 1'b1));
        load(4'd2, 2'd3, mk_hi(19'h00012, 8'h33), mk_lo(19'h0ABCD, 1'b1, 1'b1, 1'b0));
        load(4'd3, 2'd1, mk_hi(19'h00003, 8'h05), mk_lo(19'h00333, 1'b0, 1'b0, 1'b1));
        load(4'd3, 2'd0, mk_hi(19'h00013, 8'h05), mk_lo(19'h00313, 1'b0, 1'b1, 1'b1));
        load(4'd4, 2'd2, mk_hi(19'h7FFF4, 8'hFF), mk_lo(19'h00044, 1'b0, 1'b1, 1'b1));
        load(4'd6, 2'd1, mk_hi(19'h00006, 8'h05), mk_lo(19'h00111, 1'b1, 1'b1, 1'b1));
        load(4'd6, 2'd2, mk_hi(19'h00006, 8'h05), mk_lo(19'h00222, 1'b1, 1'b1, 1'b1));
        load(4'd8, 2'd0, mk_hi(19'h00008, 8'h20), mk_lo(19'h00088, 1'b0, 1'b1, 1'b0));

        for (int i = 0; i < NROW; i++) begin
            row_t r;
            string tg;
            r = ROWS[i];
            tg = $sformatf("R%0d row %0d", r.rq, i);
            @(negedge clk);
            req_valid = 1'b1; req_vaddr = r.va; req_write = r.wr; req_pid = r.pid;
            prot_cfg = mk_cfg(r.wen, r.ven); mmu_en = r.en;
            @(negedge clk);
            req_valid = 1'b0;
            if (r.vec != 4'h0) cause_m = mk_cause(r.va, r.wr, r.pid);
            if (r.vec == 4'h8 || r.vec == 4'h9) sel_m = {2'b00, r.va[16:13]};
            chk({"R3 valid ", tg}, {31'b0, rsp_valid}, 32'h1);
            chk({"vec ", tg}, {27'b0, rsp_fault, rsp_vec}, {27'b0, (r.vec != 4'h0), r.vec});
            chk({"paddr ", tg}, rsp_paddr, r.pa);
            chk({"R8 cause ", tg}, fault_cause, cause_m);
            chk({"R9 sel ", tg}, {26'b0, refill_sel}, {26'b0, sel_m});
            chk({"R10 rb ", tg}, rb_vaddr, r.rb);
        end

        // R3: valid drops after an idle cycle
        @(negedge clk);
        chk("R3 idle", {31'b0, rsp_valid}, 32'h0);

        // R13: lookup in the same cycle as the write sees the old entry
        mmu_en = 1'b1;
        prot_cfg = mk_cfg(1'b1, 1'b1);
        tlb_wr_en = 1'b1; tlb_wr_set = 4'd7; tlb_wr_way = 2'd0;
        tlb_wr_hi = mk_hi(19'h00007, 8'h05); tlb_wr_lo = mk_lo(19'h00777, 1'b0, 1'b1, 1'b1);
        req_valid = 1'b1; req_vaddr = 32'h0000_E010; req_write = 1'b0; req_pid = 8'h05;
        @(negedge clk);
        tlb_wr_en = 1'b0;
        chk("R13 same-cycle miss", {28'b0, rsp_vec}, 32'h8);
        chk("R9 sel set 7", {26'b0, refill_sel}, 32'h7);
        chk("R10 rb new entry", rb_vaddr, 32'h0000_E000);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R13 next-cycle hit vec", {28'b0, rsp_vec}, 32'h0);
        chk("R13 next-cycle hit paddr", rsp_paddr, 32'h00EE_E010);
        chk("R8 cause kept on hit", fault_cause, mk_cause(32'h0000_E010, 1'b0, 8'h05));

        done = 1'b1;
        summary();
        $finish;
    end

endmodule